// File: doc/BRIEF.md
# Immediate Operand Extension Unit

This unit turns the constant fields of a decoded instruction into a full-width operand for a small processor core whose datapath is either 16 or 32 bits wide. It receives the short 4-bit constant, the long 16-bit constant, the 4-bit secondary register field and a form code from the decoder. It also receives two per-opcode attribute bits from the decode table. The first attribute selects zero extension instead of sign extension. The second says that the opcode never reads its secondary register field.

On a 32-bit build, a long instruction whose secondary field is unused gets a wider constant. The secondary field supplies bits 19:16 of a 20-bit constant and the long field supplies bits 15:0. On a 16-bit build the secondary field is never merged. The operand is registered: it appears one clock after the request, with a valid strobe that follows the request strobe. The operand keeps its value between requests.

Top module: `imm_ext_unit`

## Requirements
- R1: While reset is high and on the first clock after it, `out_valid` is 0 and `operand` is all zeros.
- R2: `out_valid` equals the value that `in_valid` had on the previous clock edge.
- R3: With `form_sel` = 1 (short form) and `attr_unsigned` = 0, `operand` is the 4-bit `short_imm` sign-extended from bit 3 (range -8 to 7). `long_imm` and `sec_field` have no effect.
- R4: With `form_sel` = 1 and `attr_unsigned` = 1, `operand` is `short_imm` zero-extended (range 0 to 15).
- R5: With `form_sel` = 2 (long form), `attr_sec_unused` = 0 and `attr_unsigned` = 0, `operand` is `long_imm` sign-extended from bit 15, and `sec_field` has no effect.
- R6: With `form_sel` = 2, `attr_sec_unused` = 0 and `attr_unsigned` = 1, `operand` is `long_imm` zero-extended (range 0 to 65535).
- R7: On a 32-bit build with `form_sel` = 2, `attr_sec_unused` = 1 and `attr_unsigned` = 0, `operand` is {`sec_field`, `long_imm`} (secondary field in bits 19:16) sign-extended from bit 19.
- R8: On a 32-bit build with `form_sel` = 2, `attr_sec_unused` = 1 and `attr_unsigned` = 1, `operand` is {`sec_field`, `long_imm`} zero-extended from bit 19.
- R9: On a 16-bit build, `attr_sec_unused` has no effect: a long-form `operand` is always `long_imm`, whatever `sec_field` holds.
- R10: With `form_sel` = 0 (no constant) or 3 (reserved), an accepted request gives `operand` = 0.
- R11: When `in_valid` is 0 on a clock edge, `operand` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe for the decoded fields |
| form_sel | input | 2 | 0 none, 1 short, 2 long, 3 reserved |
| short_imm | input | 4 | Short constant field |
| long_imm | input | 16 | Long constant field |
| sec_field | input | 4 | Secondary register field |
| attr_unsigned | input | 1 | Opcode attribute: zero-extend the constant |
| attr_sec_unused | input | 1 | Opcode attribute: secondary field is not read |
| out_valid | output | 1 | Operand strobe, one clock after `in_valid` |
| operand | output | DATA_W | Extended constant |

## Verification
The unsigned attribute and the secondary-field merge can both apply to one long instruction. The result must then be zero-extended from bit 19, not from bit 15, and it must not be sign-extended from bit 19. The bench drives this combination with bit 3 of `sec_field` set and with bit 15 of `long_imm` set. It runs a 32-bit and a 16-bit instance side by side, so each comparison shows both the merge and its absence on the narrow build. Every operand is checked against the behavioural model on the clock after the request.

// File: rtl/imm_ext_pkg.sv
package imm_ext_pkg;

    localparam int SHORT_W   = 4;
    localparam int LONG_W    = 16;
    localparam int SEC_W     = 4;
    localparam int WIDE_W    = LONG_W + SEC_W;
    localparam int EXT_MAX_W = 32;

    typedef enum logic [1:0] {
        IMM_FORM_NONE  = 2'd0,
        IMM_FORM_SHORT = 2'd1,
        IMM_FORM_LONG  = 2'd2,
        IMM_FORM_RSVD  = 2'd3
    } imm_form_e;

    typedef struct packed {
        imm_form_e            form;
        logic [SHORT_W-1:0]   short_imm;
        logic [LONG_W-1:0]    long_imm;
        logic [SEC_W-1:0]     sec_field;
        logic                 uns;
        logic                 sec_free;
    } imm_req_t;

    // Extend a raw field whose top significant bit is at index top.
    function automatic logic [EXT_MAX_W-1:0] extend_from(
        input logic [EXT_MAX_W-1:0] raw,
        input int unsigned          top,
        input logic                 uns
    );
        logic [EXT_MAX_W-1:0] res;
        for (int i = 0; i < EXT_MAX_W; i++) begin
            if (i <= top) res[i] = raw[i];
            else          res[i] = uns ? 1'b0 : raw[top];
        end
        return res;
    endfunction

endpackage

// File: rtl/imm_ext_short.sv
module imm_ext_short
    import imm_ext_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [SHORT_W-1:0] short_imm,
    input  logic               uns,
    output logic [DATA_W-1:0]  value
);
    localparam int PAD_W = EXT_MAX_W - SHORT_W;

    logic [EXT_MAX_W-1:0] full;

    always_comb begin
        full  = extend_from({{PAD_W{1'b0}}, short_imm}, SHORT_W - 1, uns);
        value = full[DATA_W-1:0];
    end

endmodule

// File: rtl/imm_ext_long.sv
module imm_ext_long
    import imm_ext_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [LONG_W-1:0]  long_imm,
    input  logic [SEC_W-1:0]   sec_field,
    input  logic               uns,
    input  logic               sec_free,
    output logic [DATA_W-1:0]  value
);
    localparam bit MERGE_SEC = (DATA_W == 32);
    localparam int PAD_LONG  = EXT_MAX_W - LONG_W;
    localparam int PAD_WIDE  = EXT_MAX_W - WIDE_W;

    logic [EXT_MAX_W-1:0] raw;
    logic [EXT_MAX_W-1:0] full;
    int unsigned          top;

    generate
        if (MERGE_SEC) begin : g_merge
            always_comb begin
                if (sec_free) begin
                    raw = {{PAD_WIDE{1'b0}}, sec_field, long_imm};
                    top = WIDE_W - 1;
                end else begin
                    raw = {{PAD_LONG{1'b0}}, long_imm};
                    top = LONG_W - 1;
                end
            end
        end else begin : g_plain
            logic unused_sec;
            assign unused_sec = ^{sec_field, sec_free};
            always_comb begin
                raw = {{PAD_LONG{1'b0}}, long_imm};
                top = LONG_W - 1;
            end
        end
    endgenerate

    always_comb begin
        full  = extend_from(raw, top, uns);
        value = full[DATA_W-1:0];
    end

endmodule

// File: rtl/imm_ext_stage.sv
module imm_ext_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] next_value,
    output logic              out_valid,
    output logic [DATA_W-1:0] operand
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            operand   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) operand <= next_value;
        end
    end

endmodule

// File: rtl/imm_ext_unit.sv
module imm_ext_unit
    import imm_ext_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        form_sel,
    input  logic [3:0]        short_imm,
    input  logic [15:0]       long_imm,
    input  logic [3:0]        sec_field,
    input  logic              attr_unsigned,
    input  logic              attr_sec_unused,
    output logic              out_valid,
    output logic [DATA_W-1:0] operand
);

    imm_req_t          req;
    logic [DATA_W-1:0] short_val;
    logic [DATA_W-1:0] long_val;
    logic [DATA_W-1:0] next_value;

    always_comb begin
        req.form      = imm_form_e'(form_sel);
        req.short_imm = short_imm;
        req.long_imm  = long_imm;
        req.sec_field = sec_field;
        req.uns       = attr_unsigned;
        req.sec_free  = attr_sec_unused;
    end

    imm_ext_short #(.DATA_W(DATA_W)) u_short (
        .short_imm (req.short_imm),
        .uns       (req.uns),
        .value     (short_val)
    );

    imm_ext_long #(.DATA_W(DATA_W)) u_long (
        .long_imm  (req.long_imm),
        .sec_field (req.sec_field),
        .uns       (req.uns),
        .sec_free  (req.sec_free),
        .value     (long_val)
    );

    always_comb begin
        case (req.form)
            IMM_FORM_SHORT: next_value = short_val;
            IMM_FORM_LONG:  next_value = long_val;
            default:        next_value = '0;
        endcase
    end

    imm_ext_stage #(.DATA_W(DATA_W)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .next_value (next_value),
        .out_valid  (out_valid),
        .operand    (operand)
    );

endmodule

// File: rtl/imm_ext_chk.sv
module imm_ext_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        form_sel,
    input logic [3:0]        short_imm,
    input logic [15:0]       long_imm,
    input logic [3:0]        sec_field,
    input logic              attr_unsigned,
    input logic              attr_sec_unused,
    input logic              out_valid,
    input logic [DATA_W-1:0] operand
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));                               // R2

    AST_SHORT_SIGNED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel == 2'd1 && !attr_unsigned)
        |=> ($signed(operand) == $signed($past(short_imm))));                    // R3

    AST_SHORT_ZERO_TOP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel == 2'd1 && attr_unsigned)
        |=> (operand == DATA_W'($past(short_imm))));                             // R4

    AST_LONG_SIGNED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel == 2'd2 && !attr_unsigned && !attr_sec_unused)
        |=> ($signed(operand) == $signed($past(long_imm))));                     // R5

    AST_LONG_ZERO_TOP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel == 2'd2 && attr_unsigned && !attr_sec_unused)
        |=> (operand == DATA_W'($past(long_imm))));                              // R6

    generate
        if (DATA_W == 32) begin : g_wide
            AST_MERGED_SIGNED: assert property (@(posedge clk) disable iff (rst)
                (in_valid && form_sel == 2'd2 && !attr_unsigned && attr_sec_unused)
                |=> ($signed(operand) ==
                     $signed({$past(sec_field), $past(long_imm)})));            // R7
            AST_MERGED_ZERO_TOP: assert property (@(posedge clk) disable iff (rst)
                (in_valid && form_sel == 2'd2 && attr_unsigned && attr_sec_unused)
                |=> (operand == DATA_W'({$past(sec_field), $past(long_imm)}))); // R8
        end else begin : g_narrow
            AST_NARROW_NO_MERGE: assert property (@(posedge clk) disable iff (rst)
                (in_valid && form_sel == 2'd2 && attr_sec_unused)
                |=> (operand[15:0] == $past(long_imm)));                        // R9
        end
    endgenerate

    AST_NO_CONST_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (form_sel == 2'd0 || form_sel == 2'd3))
        |=> (operand == '0));                                                    // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(operand));                                         // R11

endmodule

bind imm_ext_unit imm_ext_chk #(.DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .in_valid        (in_valid),
    .form_sel        (form_sel),
    .short_imm       (short_imm),
    .long_imm        (long_imm),
    .sec_field       (sec_field),
    .attr_unsigned   (attr_unsigned),
    .attr_sec_unused (attr_sec_unused),
    .out_valid       (out_valid),
    .operand         (operand)
);

// File: tb/imm_ext_unit_tb.sv
module imm_ext_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  form_sel = 2'd0;
    logic [3:0]  short_imm = 4'd0;
    logic [15:0] long_imm = 16'd0;
    logic [3:0]  sec_field = 4'd0;
    logic        attr_unsigned = 1'b0;
    logic        attr_sec_unused = 1'b0;
    logic        vld32, vld16;
    logic [31:0] op32;
    logic [15:0] op16;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    bit     exp_vld = 0;
    longint exp32 = 0;
    longint exp16 = 0;
    string  tag32 = "R1";
    string  tag16 = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    imm_ext_unit #(.DATA_W(32)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .form_sel(form_sel),
        .short_imm(short_imm), .long_imm(long_imm), .sec_field(sec_field),
        .attr_unsigned(attr_unsigned), .attr_sec_unused(attr_sec_unused),
        .out_valid(vld32), .operand(op32)
    );

    imm_ext_unit #(.DATA_W(16)) u_dut16 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .form_sel(form_sel),
        .short_imm(short_imm), .long_imm(long_imm), .sec_field(sec_field),
        .attr_unsigned(attr_unsigned), .attr_sec_unused(attr_sec_unused),
        .out_valid(vld16), .operand(op16)
    );

    function automatic longint model(int w, logic [1:0] f, logic [3:0] s,
                                     logic [15:0] l, logic [3:0] sec,
                                     bit uns, bit secu);
        longint v;
        longint mask;
        mask = (longint'(1) << w) - 1;
        case (f)
            2'd1: begin
                v = longint'(s);
                if (!uns && v >= 8) v = v - 16;
            end
            2'd2: begin
                if (w == 32 && secu) begin
                    v = longint'(sec) * 65536 + longint'(l);
                    if (!uns && v >= 524288) v = v - 1048576;
                end else begin
                    v = longint'(l);
                    if (!uns && v >= 32768) v = v - 65536;
                end
            end
            default: v = 0;
        endcase
        return v & mask;
    endfunction

    function automatic string tag_of(bit wide, logic [1:0] f, bit uns, bit secu);
        if (f == 2'd1) return uns ? "R4" : "R3";
        if (f == 2'd2) begin
            if (secu && !wide) return "R9";
            if (secu) return uns ? "R8" : "R7";
            return uns ? "R6" : "R5";
        end
        return "R10";
    endfunction

    task automatic check(string tag, longint act, longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare at the falling edge, then drive the next request.
    task automatic step(bit v, logic [1:0] f, logic [3:0] s, logic [15:0] l,
                        logic [3:0] sec, bit uns, bit secu);
        @(negedge clk);
        check("R2", longint'(vld32), longint'(exp_vld));
        check("R2", longint'(vld16), longint'(exp_vld));
        check(tag32, longint'(op32), exp32);
        check(tag16, longint'(op16), exp16);
        in_valid = v; form_sel = f; short_imm = s; long_imm = l;
        sec_field = sec; attr_unsigned = uns; attr_sec_unused = secu;
        exp_vld = v;
        if (v) begin
            exp32 = model(32, f, s, l, sec, uns, secu);
            exp16 = model(16, f, s, l, sec, uns, secu);
            tag32 = tag_of(1, f, uns, secu);
            tag16 = tag_of(0, f, uns, secu);
        end else begin
            tag32 = "R11";
            tag16 = "R11";
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        check("R1", longint'(vld32), 0);
        check("R1", longint'(op32), 0);
        check("R1", longint'(op16), 0);
        rst = 1'b0;
        // R1: first clock after reset is checked by the first step
        step(1, 2'd1, 4'h8, 16'h1234, 4'hF, 0, 0);   // R3 -8
        step(1, 2'd1, 4'h7, 16'h0000, 4'h0, 0, 0);   // R3 +7
        step(1, 2'd1, 4'hF, 16'hFFFF, 4'hF, 1, 0);   // R4 15
        step(1, 2'd2, 4'h0, 16'h8000, 4'hA, 0, 0);   // R5 -32768
        step(1, 2'd2, 4'h0, 16'h7FFF, 4'hF, 0, 0);   // R5 32767
        step(1, 2'd2, 4'h0, 16'hFFFF, 4'h5, 1, 0);   // R6 65535
        step(1, 2'd2, 4'h0, 16'h0001, 4'h8, 0, 1);   // R7 negative 20-bit, R9
        step(1, 2'd2, 4'h0, 16'hFFFF, 4'h7, 0, 1);   // R7 positive, bit15 set
        step(1, 2'd2, 4'h0, 16'h8000, 4'hF, 1, 1);   // R8 unsigned + merge
        step(1, 2'd0, 4'hF, 16'hFFFF, 4'hF, 0, 0);   // R10 none
        step(1, 2'd3, 4'hF, 16'hFFFF, 4'hF, 1, 1);   // R10 reserved
        step(1, 2'd2, 4'h0, 16'hC3C3, 4'h9, 0, 1);   // load value
        step(0, 2'd1, 4'h1, 16'h0000, 4'h0, 0, 0);   // R11 hold
        step(0, 2'd2, 4'h0, 16'h0055, 4'h2, 1, 1);   // R11 hold
        for (int i = 0; i < 400; i++) begin
            step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
                 4'($urandom), 16'($urandom), 4'($urandom),
                 1'($urandom), 1'($urandom));
        end
        step(0, 2'd0, 4'h0, 16'h0000, 4'h0, 0, 0);
        step(0, 2'd0, 4'h0, 16'h0000, 4'h0, 0, 0);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule